// File: doc/BRIEF.md
# Eight-Counter Event Performance Monitor

This block counts traffic events for a performance monitor. It has eight 64-bit counters. Each counter picks what it counts through its own 8-bit event code. The choices are plain clock cycles and the read-data or write-data beats of two traffic ports. Event beats arrive as single-cycle pulses on a small input vector.

A counter advances only when both the run bit and its own enable bit are set. When a counter rolls over from all ones to zero, it raises a sticky status bit. Each status bit can raise the level interrupt unless its mask bit hides it.

Software reaches every register over a simple 32-bit register bus. Writes take effect on the clock edge where select and write are both high. Read data is combinational while select is high and write is low. The bus also reaches a version word and one configuration bit that holds off power management while counting runs.

Top module: `evmon_top`

## Requirements
- R1: After reset the following hold: all counters read 0, the run bit and all per-counter enables read 0, the mask at 0x1C70 reads 0xFF (everything masked), status reads 0, the configuration word reads 0, and both `irq_out` and `pm_hold` are low.
- R2: Counter n has its low word at 0x1D00 + 8·n and its high word 4 bytes above. Both words can be read and written, and a write to one word leaves the other word unchanged.
- R3: Event codes are 8 bits wide. The word at 0x1C80 holds the codes for counters 0 to 3 and the word at 0x1C84 holds those for counters 4 to 7. Counter n uses byte n mod 4, that is bits [8·(n mod 4)+7 : 8·(n mod 4)], and these words read back as written.
- R4: The event codes decode as follows. `evt_in` bit 0 is a port 0 write beat, bit 1 a port 0 read beat, bit 2 a port 1 write beat and bit 3 a port 1 read beat. Code 0x00 counts every clock. Code 0xE1 counts bit 0, 0xE2 counts bit 1, 0x61 counts bit 2 and 0x62 counts bit 3. Every other code counts nothing.
- R5: While bit 0 of the run word at 0x1C00 is 0, no counter advances.
- R6: Bit n of the enable word at 0x1C04 gates counter n. A counter whose bit is 0 does not advance even while the run bit is set.
- R7: When a counter advances from all ones, it becomes 0 and sets bit n of the status word at 0x1C78.
- R8: `irq_out` is high exactly when some status bit is set whose mask bit (0x1C70) is 0. Writing 1 to a mask bit hides that counter's status.
- R9: Writing 1 to bit n of 0x1C7C clears status bit n. Writing 0 there has no effect, and writes to 0x1C78 itself have no effect.
- R10: If a clear of bit n and an overflow of counter n land on the same clock edge, status bit n ends up set.
- R11: 0x1CF0 reads the `VERSION` parameter. Bit 9 of 0x0534 can be read and written, and its value drives `pm_hold`.
- R12: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (16) | Byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data; 0 when no read is in progress |
| evt_in | input | 4 | Event beat pulses, encoded as in R4 |
| pm_hold | output | 1 | Power management hold, from configuration bit 9 |
| irq_out | output | 1 | Level overflow interrupt |

## Verification
Two functions can fall on the same edge: a software clear of a status bit and a fresh rollover of that same counter. The bench provokes the collision by loading the counter with all ones while the run bit is 0. It then sets the run bit and issues the clear write on the very next edge, which is the edge where the counter wraps. The status bit must read back as set, and the counter must show that exactly one further count followed. A second same-cycle case is a bus write to a counter word on an edge where the counter would also count; there the written value must be what reads back.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
   // Event pulse vector bit positions
   localparam int unsigned EVB_P0_WR = 0;
   localparam int unsigned EVB_P0_RD = 1;
   localparam int unsigned EVB_P1_WR = 2;
   localparam int unsigned EVB_P1_RD = 3;
   localparam int unsigned EV_W      = 4;

   // Event codes
   localparam logic [7:0] EC_CYCLE = 8'h00;
   localparam logic [7:0] EC_P1_WR = 8'h61;
   localparam logic [7:0] EC_P1_RD = 8'h62;
   localparam logic [7:0] EC_P0_WR = 8'hE1;
   localparam logic [7:0] EC_P0_RD = 8'hE2;

   // Register byte offsets
   localparam int unsigned OFS_RUN    = 'h1C00;
   localparam int unsigned OFS_ENA    = 'h1C04;
   localparam int unsigned OFS_MASK   = 'h1C70;
   localparam int unsigned OFS_STAT   = 'h1C78;
   localparam int unsigned OFS_CLR    = 'h1C7C;
   localparam int unsigned OFS_SEL    = 'h1C80;
   localparam int unsigned OFS_VER    = 'h1CF0;
   localparam int unsigned OFS_CNT    = 'h1D00;
   localparam int unsigned OFS_CFG    = 'h0534;
   localparam int unsigned CFG_PM_BIT = 9;
   localparam int unsigned CODES_PER_WORD = 4;
endpackage

// File: rtl/evmon_evdec.sv
module evmon_evdec
   import evmon_pkg::*;
(
   input  logic [7:0]      code,
   input  logic [EV_W-1:0] evt,
   output logic            hit
);
   always_comb begin
      case (code)
         EC_CYCLE: hit = 1'b1;
         EC_P0_WR: hit = evt[EVB_P0_WR];
         EC_P0_RD: hit = evt[EVB_P0_RD];
         EC_P1_WR: hit = evt[EVB_P1_WR];
         EC_P1_RD: hit = evt[EVB_P1_RD];
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
   parameter int unsigned CW = 64,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [DW-1:0] wdata,
   output logic [CW-1:0] value,
   output logic          ovf
);
   localparam int unsigned HW = CW - DW;

   logic [CW-1:0] cnt_q;
   logic          wr_any;

   assign wr_any = wr_lo | wr_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_any) begin
         if (wr_lo) cnt_q[DW-1:0]  <= wdata;
         if (wr_hi) cnt_q[CW-1:DW] <= wdata[HW-1:0];
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign value = cnt_q;
   assign ovf   = inc & ~wr_any & (&cnt_q);

   // R5/R6: with no count request and no write the value holds
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc || wr_lo || wr_hi) |=> $stable(cnt_q));

   // R7: advancing from all ones lands on zero
   p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_lo && !wr_hi && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/evmon_irq.sv
module evmon_irq #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ovf,
   input  logic         clr_we,
   input  logic [N-1:0] clr_bits,
   input  logic [N-1:0] mask,
   output logic [N-1:0] status,
   output logic         irq
);
   logic [N-1:0] stat_q;
   logic [N-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_eff) | ovf;
   end

   assign status = stat_q;
   assign irq    = |(stat_q & ~mask);

   // R7/R10: an overflow always leaves its status bit set
   p_ovf_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf != '0) |=> ((stat_q & $past(ovf)) == $past(ovf)));

   // R9: a one in the clear word drops the bit unless it overflowed
   p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((stat_q & $past(clr_bits & ~ovf)) == '0));

   // R9: nothing else moves status
   p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && ovf == '0) |=> $stable(stat_q));
endmodule

// File: rtl/evmon_top.sv
module evmon_top
   import evmon_pkg::*;
#(
   parameter int unsigned   N_CTR   = 8,
   parameter int unsigned   CTR_W   = 64,
   parameter int unsigned   DW      = 32,
   parameter int unsigned   AW      = 16,
   parameter logic [DW-1:0] VERSION = 32'h0001_0A17
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [EV_W-1:0] evt_in,
   output logic            pm_hold,
   output logic            irq_out
);
   localparam int unsigned CNT_STRIDE = 8;
   localparam int unsigned HALF_OFS   = 4;

   if (N_CTR < 1 || N_CTR > 2 * CODES_PER_WORD) begin : g_bad_n
      $error("N_CTR must be 1..8");
   end
   if (CTR_W <= DW || CTR_W > 2 * DW) begin : g_bad_w
      $error("CTR_W must exceed DW and fit two bus words");
   end
   if (AW < 13 || DW < 16) begin : g_bad_bus
      $error("bus too narrow for the register map");
   end

   logic                        wr_en;
   logic                        run_q;
   logic                        pm_q;
   logic [N_CTR-1:0]            ena_q;
   logic [N_CTR-1:0]            mask_q;
   logic [N_CTR-1:0][7:0]       sel_q;
   logic [N_CTR-1:0][CTR_W-1:0] cnt_vals;
   logic [N_CTR-1:0]            ovf_vec;
   logic [N_CTR-1:0]            stat_vec;
   logic                        clr_we;
   logic [DW-1:0]               rd_mux;

   assign wr_en  = bus_sel & bus_wr;
   assign clr_we = wr_en && (bus_addr == AW'(OFS_CLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pm_q   <= 1'b0;
         ena_q  <= '0;
         mask_q <= '1;
         sel_q  <= '0;
      end else if (wr_en) begin
         if (bus_addr == AW'(OFS_RUN))  run_q  <= bus_wdata[0];
         if (bus_addr == AW'(OFS_ENA))  ena_q  <= bus_wdata[N_CTR-1:0];
         if (bus_addr == AW'(OFS_MASK)) mask_q <= bus_wdata[N_CTR-1:0];
         if (bus_addr == AW'(OFS_CFG))  pm_q   <= bus_wdata[CFG_PM_BIT];
         for (int n = 0; n < N_CTR; n++) begin
            if (bus_addr == AW'(OFS_SEL + 4 * (n / CODES_PER_WORD)))
               sel_q[n] <= bus_wdata[8 * (n % CODES_PER_WORD) +: 8];
         end
      end
   end

   for (genvar n = 0; n < N_CTR; n++) begin : g_ctr
      logic hit;
      logic inc;
      logic wlo;
      logic whi;

      evmon_evdec u_dec (
         .code (sel_q[n]),
         .evt  (evt_in),
         .hit  (hit)
      );

      assign inc = run_q & ena_q[n] & hit;
      assign wlo = wr_en && (bus_addr == AW'(OFS_CNT + CNT_STRIDE * n));
      assign whi = wr_en && (bus_addr == AW'(OFS_CNT + CNT_STRIDE * n + HALF_OFS));

      evmon_counter #(.CW(CTR_W), .DW(DW)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc),
         .wr_lo (wlo),
         .wr_hi (whi),
         .wdata (bus_wdata),
         .value (cnt_vals[n]),
         .ovf   (ovf_vec[n])
      );
   end

   evmon_irq #(.N(N_CTR)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf      (ovf_vec),
      .clr_we   (clr_we),
      .clr_bits (bus_wdata[N_CTR-1:0]),
      .mask     (mask_q),
      .status   (stat_vec),
      .irq      (irq_out)
   );

   always_comb begin
      rd_mux = '0;
      if (bus_addr == AW'(OFS_RUN))  rd_mux[0] = run_q;
      if (bus_addr == AW'(OFS_ENA))  rd_mux[N_CTR-1:0] = ena_q;
      if (bus_addr == AW'(OFS_MASK)) rd_mux[N_CTR-1:0] = mask_q;
      if (bus_addr == AW'(OFS_STAT)) rd_mux[N_CTR-1:0] = stat_vec;
      if (bus_addr == AW'(OFS_VER))  rd_mux = VERSION;
      if (bus_addr == AW'(OFS_CFG))  rd_mux[CFG_PM_BIT] = pm_q;
      for (int n = 0; n < N_CTR; n++) begin
         if (bus_addr == AW'(OFS_SEL + 4 * (n / CODES_PER_WORD)))
            rd_mux[8 * (n % CODES_PER_WORD) +: 8] = sel_q[n];
         if (bus_addr == AW'(OFS_CNT + CNT_STRIDE * n))
            rd_mux = cnt_vals[n][DW-1:0];
         if (bus_addr == AW'(OFS_CNT + CNT_STRIDE * n + HALF_OFS))
            rd_mux = DW'(cnt_vals[n][CTR_W-1:DW]);
      end
   end

   assign bus_rdata = (bus_sel && !bus_wr) ? rd_mux : '0;
   assign pm_hold   = pm_q;

   // R11: the hold output only moves on a configuration write
   p_pm_write_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && bus_addr == AW'(OFS_CFG)) |=> $stable(pm_hold));
endmodule

// File: tb/sim_evmon_top.sv
module sim_evmon_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  evt_in = '0;
   logic        pm_hold;
   logic        irq_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam logic [31:0] VER = 32'h0001_0A17;

   always #2 clk = ~clk;

   evmon_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_in(evt_in), .pm_hold(pm_hold), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 16'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 16'(a);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rd_cnt(input int n, output logic [63:0] v);
      logic [31:0] lo, hi;
      rd('h1D00 + 8 * n, lo);
      rd('h1D04 + 8 * n, hi);
      v = {hi, lo};
   endtask

   task automatic wr_cnt(input int n, input logic [63:0] v);
      wr('h1D00 + 8 * n, v[31:0]);
      wr('h1D04 + 8 * n, v[63:32]);
   endtask

   task automatic run_for(input int idle);
      wr('h1C00, 32'h1);
      repeat (idle) @(negedge clk);
      wr('h1C00, 32'h0);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      logic [63:0] v;
      rd('h1C00, d); chk("R1 run", d, 0);
      rd('h1C04, d); chk("R1 enables", d, 0);
      rd('h1C70, d); chk("R1 mask", d, 32'hFF);
      rd('h1C78, d); chk("R1 status", d, 0);
      rd('h0534, d); chk("R1 config", d, 0);
      rd_cnt(0, v);  chk("R1 counter0", v, 0);
      rd_cnt(7, v);  chk("R1 counter7", v, 0);
      chk("R1 irq", irq_out, 0);
      chk("R1 pm_hold", pm_hold, 0);
      rd('h1CF0, d); chk("R11 version", d, VER);
      rd('h1C40, d); chk("R12 unmapped", d, 0);
      rd('h1C7C, d); chk("R12 clear word reads zero", d, 0);
   endtask

   task automatic t_halves;
      logic [63:0] v;
      wr_cnt(3, 64'hAABBCCDD_11223344);
      rd_cnt(3, v); chk("R2 full write", v, 64'hAABBCCDD_11223344);
      wr('h1D18, 32'h0000_0055);
      rd_cnt(3, v); chk("R2 low only", v, 64'hAABBCCDD_00000055);
      wr('h1D1C, 32'h0102_0304);
      rd_cnt(3, v); chk("R2 high only", v, 64'h01020304_00000055);
   endtask

   task automatic t_cycles;
      logic [31:0] d;
      logic [63:0] v;
      wr('h1C84, 32'h5555_0055);
      rd('h1C84, d); chk("R3 select readback", d, 32'h5555_0055);
      wr('h1C04, 32'h30);
      run_for(6);
      rd_cnt(5, v); chk("R4 cycle code", v, 7);
      rd_cnt(4, v); chk("R4 unknown code 0x55", v, 0);
   endtask

   task automatic t_ports;
      logic [31:0] d;
      logic [63:0] v;
      wr_cnt(3, 64'h0);
      wr('h1C80, 32'hE2E1_6261);
      rd('h1C80, d); chk("R3 select word 0", d, 32'hE2E1_6261);
      wr('h1C84, 32'h5555_5555);
      wr('h1C04, 32'h1F);
      wr('h1C00, 32'h1);
      for (int i = 0; i < 3; i++) begin evt_in = 4'b0001; @(negedge clk); end
      for (int i = 0; i < 2; i++) begin evt_in = 4'b0110; @(negedge clk); end
      evt_in = 4'b1111; @(negedge clk);
      for (int i = 0; i < 4; i++) begin evt_in = 4'b1000; @(negedge clk); end
      evt_in = 4'b0000;
      wr('h1C00, 32'h0);
      rd_cnt(0, v); chk("R4 0x61 port1 write", v, 3);
      rd_cnt(1, v); chk("R4 0x62 port1 read", v, 5);
      rd_cnt(2, v); chk("R4 0xE1 port0 write", v, 4);
      rd_cnt(3, v); chk("R4 0xE2 port0 read", v, 3);
      rd_cnt(4, v); chk("R4 other code", v, 0);
   endtask

   task automatic t_gates;
      logic [63:0] v;
      wr('h1C80, 32'h0);
      wr_cnt(0, 64'h0);
      wr('h1C04, 32'h01);
      repeat (10) @(negedge clk);
      rd_cnt(0, v); chk("R5 run clear holds", v, 0);
      wr('h1C04, 32'h02);
      run_for(3);
      rd_cnt(0, v); chk("R6 disabled counter", v, 0);
      rd_cnt(1, v); chk("R6 enabled counter", v, 9);
   endtask

   task automatic t_overflow;
      logic [31:0] d;
      logic [63:0] v;
      wr_cnt(2, 64'hFFFFFFFF_FFFFFFFD);
      wr('h1C04, 32'h04);
      run_for(4);
      rd_cnt(2, v); chk("R7 wrapped value", v, 2);
      rd('h1C78, d); chk("R7 status set", d, 32'h04);
      chk("R8 masked irq", irq_out, 0);
      wr('h1C70, 32'hFB);
      chk("R8 unmasked irq", irq_out, 1);
      wr('h1C70, 32'hFF);
      chk("R8 remasked irq", irq_out, 0);
      wr('h1C70, 32'hFB);
      wr('h1C78, 32'h0);
      rd('h1C78, d); chk("R9 status read-only", d, 32'h04);
      wr('h1C7C, 32'h0);
      rd('h1C78, d); chk("R9 write zero no effect", d, 32'h04);
      chk("R9 irq still up", irq_out, 1);
      wr('h1C7C, 32'h04);
      rd('h1C78, d); chk("R9 clear", d, 0);
      chk("R9 irq dropped", irq_out, 0);
   endtask

   task automatic t_collide;
      logic [31:0] d;
      logic [63:0] v;
      wr_cnt(2, 64'hFFFFFFFF_FFFFFFFF);
      wr('h1C00, 32'h1);
      wr('h1C7C, 32'h04);
      wr('h1C00, 32'h0);
      rd('h1C78, d); chk("R10 overflow beats clear", d, 32'h04);
      rd_cnt(2, v); chk("R10 counter after wrap", v, 1);
      chk("R10 irq", irq_out, 1);
      wr('h1C7C, 32'h04);
   endtask

   task automatic t_write_vs_count;
      logic [63:0] v;
      wr('h1C04, 32'h01);
      wr('h1C00, 32'h1);
      wr('h1D00, 32'h0000_1000);
      wr('h1C00, 32'h0);
      rd_cnt(0, v); chk("R2 write beats count", v, 64'h1001);
   endtask

   task automatic t_cfg;
      logic [31:0] d;
      wr('h0534, 32'h0000_0200);
      rd('h0534, d); chk("R11 config readback", d, 32'h200);
      chk("R11 pm_hold set", pm_hold, 1);
      wr('h0534, 32'h0);
      chk("R11 pm_hold clear", pm_hold, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_halves();
      t_cycles();
      t_ports();
      t_gates();
      t_overflow();
      t_collide();
      t_write_vs_count();
      t_cfg();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule